// File: doc/BRIEF.md
# 4PPM Preamble and Start-Flag Synchroniser

This block sits behind a slot timer that recovers four-slot 4PPM chips from a receive line. It takes one chip per valid strobe and gains frame alignment in two steps. It starts from whatever chip boundary the timer happens to deliver and checks each group of four chips against the preamble pattern. After every failed group it asks the timer to slip by one slot. Once a group matches, the block stays locked for as long as the preamble keeps repeating, because an idle line repeats it without limit.

While locked, the block watches each group boundary for the first chip of the eight-chip start flag. A complete and correct start flag opens the frame. From then on, every four one-hot chips are packed into one byte, and a byte-valid strobe is raised for each finished byte. A chip that is not one-hot marks either the start of the stop flag or a framing fault. A correct stop flag closes the frame with a frame-end pulse. Any mismatch inside the start or stop flag, and any stray non-one-hot chip, produces a framing-error pulse. In every one of these cases the block goes back to preamble search.

Top module: `ppm4_sync`

## Requirements
- R1: While `rst` is high or `enable` is low, every output is low on the next clock. Chips offered while `enable` is low are ignored, and after `enable` rises the search starts at a fresh group.
- R2: In search, every fourth accepted chip ends a group. If any chip of the group differs from the preamble (default, earliest chip first: 1000, 0000, 1010, 0000, with `chip_slots[3]` as the earliest slot), `slot_skip` is high for one cycle, one clock after the fourth chip.
- R3: A group that matches the preamble locks the block without a skip. While locked, any number of further preamble repetitions produce no pulse and leave `in_frame` low.
- R4: While locked, a chip at a group boundary that equals the first start-flag chip begins the start flag (default 0000, 1100, 0000, 1100, 0110, 0000, 0110, 0000). When all eight chips match, `in_frame` rises one clock after the eighth chip.
- R5: Any start-flag chip that differs from the expected one gives a one-cycle `frame_err` one clock later, keeps `in_frame` low and returns the block to search.
- R6: In a frame, data chips decode as 1000 to 0, 0100 to 1, 0010 to 2 and 0001 to 3. The first chip of a group supplies bits 1:0 and the fourth supplies bits 7:6. `byte_vld` pulses for one cycle with `byte_data`, one clock after the fourth chip.
- R7: In a frame, a non-one-hot chip that is not the first chip of a group, or that differs from the first stop-flag chip, gives `frame_err` and drops `in_frame` one clock later. The partial byte is discarded and the block returns to search.
- R8: In a frame, a non-one-hot chip at a group boundary that equals the first stop-flag chip begins the stop flag (default 0000, 1100, 0000, 1100, 0000, 0110, 0000, 0110). When all eight chips match, `frame_end` pulses and `in_frame` falls, one clock after the eighth chip. The block then returns to search.
- R9: A stop-flag chip that differs from the expected one gives `frame_err` and drops `in_frame` one clock later.
- R10: While locked, a chip that matches neither the preamble nor, at a group boundary, the first start-flag chip returns the block to search. This produces no skip and no error, and the next group is compared from its first chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver enable; low clears the block |
| chip_vld | input | 1 | A chip is offered on `chip_slots` this cycle |
| chip_slots | input | 4 | One chip, bit 3 is the earliest slot |
| slot_skip | output | 1 | Request to slip the slot timer by one slot |
| byte_vld | output | 1 | `byte_data` holds a new byte |
| byte_data | output | 8 | Last decoded data byte |
| frame_err | output | 1 | Framing-error pulse |
| frame_end | output | 1 | Stop flag recognised |
| in_frame | output | 1 | Between a valid start flag and the frame end or error |

## Verification
Every result of this block is registered, so each one is due exactly one clock after the edge that accepts the chip causing it, whether that is the skip request, the byte strobe, a framing error, the frame end or a change of `in_frame`. The bench offers one chip every two cycles. Its driver queues the expected output set for each chip. The monitor notes at the rising edge whether a chip was taken and compares the outputs at the next falling edge. Cycles with no chip must show no pulse at all. In the hunt stimulus, the bench builds chips from a slot stream that its own model slips, so a missing or extra skip shows up both as a miscompare and as wrong chips afterwards.

// File: rtl/ppm4_sync_pkg.sv
`timescale 1ns/1ps
package ppm4_sync_pkg;

    localparam int SLOTS = 4;
    typedef logic [SLOTS-1:0] chip_t;

    // Chip 0 sits in the most significant nibble; bit 3 of a chip is its earliest slot.
    localparam logic [15:0] DEF_PREAMBLE = 16'b1000_0000_1010_0000;
    localparam logic [31:0] DEF_START    = 32'b0000_1100_0000_1100_0110_0000_0110_0000;
    localparam logic [31:0] DEF_STOP     = 32'b0000_1100_0000_1100_0000_0110_0000_0110;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LOCK,
        ST_START,
        ST_DATA,
        ST_STOP
    } sync_state_e;

    typedef struct packed {
        logic skip;
        logic bvld;
        logic err;
        logic fend;
        logic inf;
    } sync_flags_t;

    function automatic logic chip_is_sym(chip_t c);
        return (c != '0) && ((c & (c - chip_t'(1))) == '0);
    endfunction

    function automatic logic [1:0] chip_sym(chip_t c);
        logic [1:0] s;
        case (c)
            4'b1000: s = 2'd0;
            4'b0100: s = 2'd1;
            4'b0010: s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ppm4_pattern_pick.sv
`timescale 1ns/1ps
module ppm4_pattern_pick
    import ppm4_sync_pkg::*;
#(
    parameter int                  CHIPS   = 4,
    parameter logic [CHIPS*4-1:0]  PATTERN = '0,
    localparam int                 IW      = (CHIPS > 1) ? $clog2(CHIPS) : 1
) (
    input  logic [IW-1:0] idx,
    output chip_t         chip
);

    chip_t table_q [CHIPS];

    for (genvar k = 0; k < CHIPS; k++) begin : g_chip
        assign table_q[k] = PATTERN[4*(CHIPS-1-k) +: 4];
    end

    assign chip = table_q[idx];

endmodule

// File: rtl/ppm4_chip_decode.sv
`timescale 1ns/1ps
module ppm4_chip_decode
    import ppm4_sync_pkg::*;
(
    input  chip_t       chip,
    output logic        is_sym,
    output logic [1:0]  sym
);

    always_comb begin
        is_sym = chip_is_sym(chip);
        sym    = chip_sym(chip);
    end

endmodule

// File: rtl/ppm4_byte_pack.sv
`timescale 1ns/1ps
module ppm4_byte_pack #(
    parameter int  BYTE_W = 8,
    localparam int NCH    = BYTE_W / 2,
    localparam int PW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [PW-1:0]     pos,
    input  logic [1:0]        sym,
    output logic [BYTE_W-1:0] assembled
);

    logic [BYTE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (shift_en) begin
            acc_q[2*pos +: 2] <= sym;
        end
    end

    always_comb begin
        assembled = acc_q;
        assembled[2*pos +: 2] = sym;
    end

endmodule

// File: rtl/ppm4_sync.sv
`timescale 1ns/1ps
module ppm4_sync
    import ppm4_sync_pkg::*;
#(
    parameter int                       PRE_CHIPS  = 4,
    parameter int                       FLAG_CHIPS = 8,
    parameter int                       BYTE_W     = 8,
    parameter logic [PRE_CHIPS*4-1:0]   PREAMBLE   = DEF_PREAMBLE,
    parameter logic [FLAG_CHIPS*4-1:0]  START_FLAG = DEF_START,
    parameter logic [FLAG_CHIPS*4-1:0]  STOP_FLAG  = DEF_STOP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              chip_vld,
    input  logic [3:0]        chip_slots,
    output logic              slot_skip,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_err,
    output logic              frame_end,
    output logic              in_frame
);

    localparam int BYTE_CHIPS = BYTE_W / 2;
    localparam int MAX_A      = (PRE_CHIPS > BYTE_CHIPS) ? PRE_CHIPS : BYTE_CHIPS;
    localparam int MAXC       = (FLAG_CHIPS > MAX_A) ? FLAG_CHIPS : MAX_A;
    localparam int CIW        = $clog2(MAXC);
    localparam int PIW        = (PRE_CHIPS > 1) ? $clog2(PRE_CHIPS) : 1;
    localparam int FIW        = (FLAG_CHIPS > 1) ? $clog2(FLAG_CHIPS) : 1;
    localparam int BIW        = (BYTE_CHIPS > 1) ? $clog2(BYTE_CHIPS) : 1;

    sync_state_e       state_q;
    logic [CIW-1:0]    cidx_q;
    logic              hunt_bad_q;
    sync_flags_t       flags_q;
    logic [BYTE_W-1:0] byte_q;

    chip_t             pre_exp, start_exp, stop_exp;
    logic              is_sym;
    logic [1:0]        sym;
    logic [BYTE_W-1:0] packed_byte;
    logic              pre_hit, start_hit, stop_hit;
    logic              pre_last, flag_last, byte_last, at_group;
    logic              pack_en;

    ppm4_pattern_pick #(.CHIPS(PRE_CHIPS), .PATTERN(PREAMBLE)) i_pre_pick (
        .idx  (cidx_q[PIW-1:0]),
        .chip (pre_exp)
    );

    ppm4_pattern_pick #(.CHIPS(FLAG_CHIPS), .PATTERN(START_FLAG)) i_start_pick (
        .idx  (cidx_q[FIW-1:0]),
        .chip (start_exp)
    );

    ppm4_pattern_pick #(.CHIPS(FLAG_CHIPS), .PATTERN(STOP_FLAG)) i_stop_pick (
        .idx  (cidx_q[FIW-1:0]),
        .chip (stop_exp)
    );

    ppm4_chip_decode i_decode (
        .chip   (chip_slots),
        .is_sym (is_sym),
        .sym    (sym)
    );

    assign pack_en = enable && chip_vld && (state_q == ST_DATA) && is_sym;

    ppm4_byte_pack #(.BYTE_W(BYTE_W)) i_pack (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (pack_en),
        .pos       (cidx_q[BIW-1:0]),
        .sym       (sym),
        .assembled (packed_byte)
    );

    always_comb begin
        pre_hit   = (chip_slots == pre_exp);
        start_hit = (chip_slots == start_exp);
        stop_hit  = (chip_slots == stop_exp);
        pre_last  = (cidx_q == CIW'(PRE_CHIPS - 1));
        flag_last = (cidx_q == CIW'(FLAG_CHIPS - 1));
        byte_last = (cidx_q == CIW'(BYTE_CHIPS - 1));
        at_group  = (cidx_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q    <= ST_HUNT;
            cidx_q     <= '0;
            hunt_bad_q <= 1'b0;
            flags_q    <= '0;
            byte_q     <= '0;
        end else begin
            flags_q.skip <= 1'b0;
            flags_q.bvld <= 1'b0;
            flags_q.err  <= 1'b0;
            flags_q.fend <= 1'b0;
            if (chip_vld) begin
                if (state_q != ST_HUNT) hunt_bad_q <= 1'b0;
                case (state_q)
                    ST_HUNT: begin
                        if (pre_last) begin
                            cidx_q     <= '0;
                            hunt_bad_q <= 1'b0;
                            if (hunt_bad_q || !pre_hit) flags_q.skip <= 1'b1;
                            else                        state_q      <= ST_LOCK;
                        end else begin
                            cidx_q     <= cidx_q + 1'b1;
                            hunt_bad_q <= hunt_bad_q | !pre_hit;
                        end
                    end
                    ST_LOCK: begin
                        if (pre_hit) begin
                            cidx_q <= pre_last ? '0 : cidx_q + 1'b1;
                        end else if (at_group && start_hit) begin
                            state_q <= ST_START;
                            cidx_q  <= CIW'(1);
                        end else begin
                            state_q <= ST_HUNT;
                            cidx_q  <= '0;
                        end
                    end
                    ST_START: begin
                        if (!start_hit) begin
                            flags_q.err <= 1'b1;
                            state_q     <= ST_HUNT;
                            cidx_q      <= '0;
                        end else if (flag_last) begin
                            flags_q.inf <= 1'b1;
                            state_q     <= ST_DATA;
                            cidx_q      <= '0;
                        end else begin
                            cidx_q <= cidx_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (is_sym) begin
                            if (byte_last) begin
                                flags_q.bvld <= 1'b1;
                                byte_q       <= packed_byte;
                                cidx_q       <= '0;
                            end else begin
                                cidx_q <= cidx_q + 1'b1;
                            end
                        end else if (at_group && stop_hit) begin
                            state_q <= ST_STOP;
                            cidx_q  <= CIW'(1);
                        end else begin
                            flags_q.err <= 1'b1;
                            flags_q.inf <= 1'b0;
                            state_q     <= ST_HUNT;
                            cidx_q      <= '0;
                        end
                    end
                    ST_STOP: begin
                        if (!stop_hit) begin
                            flags_q.err <= 1'b1;
                            flags_q.inf <= 1'b0;
                            state_q     <= ST_HUNT;
                            cidx_q      <= '0;
                        end else if (flag_last) begin
                            flags_q.fend <= 1'b1;
                            flags_q.inf  <= 1'b0;
                            state_q      <= ST_HUNT;
                            cidx_q       <= '0;
                        end else begin
                            cidx_q <= cidx_q + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= ST_HUNT;
                        cidx_q  <= '0;
                    end
                endcase
            end
        end
    end

    assign slot_skip = flags_q.skip;
    assign byte_vld  = flags_q.bvld;
    assign byte_data = byte_q;
    assign frame_err = flags_q.err;
    assign frame_end = flags_q.fend;
    assign in_frame  = flags_q.inf;

endmodule

// File: rtl/ppm4_sync_chk.sv
`timescale 1ns/1ps
module ppm4_sync_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic chip_vld,
    input logic slot_skip,
    input logic byte_vld,
    input logic frame_err,
    input logic frame_end,
    input logic in_frame
);

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!in_frame && !byte_vld && !slot_skip && !frame_err && !frame_end));

    // R2
    skip_single_chk: assert property (@(posedge clk) disable iff (rst)
        slot_skip |=> !slot_skip);

    // R2
    skip_outside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        slot_skip |-> !in_frame);

    // R4
    frame_open_by_chip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> $past(chip_vld));

    // R6
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> (in_frame && $past(chip_vld)));

    // R7
    err_closes_frame_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !in_frame);

    // R8
    end_closes_frame_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (!in_frame && $past(in_frame)));

    // R9
    end_err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_end && frame_err));

endmodule

bind ppm4_sync ppm4_sync_chk i_ppm4_sync_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .chip_vld  (chip_vld),
    .slot_skip (slot_skip),
    .byte_vld  (byte_vld),
    .frame_err (frame_err),
    .frame_end (frame_end),
    .in_frame  (in_frame)
);

// File: tb/test_ppm4_sync.sv
`timescale 1ns/1ps
module test_ppm4_sync;

    localparam logic [15:0] PRE   = 16'b1000_0000_1010_0000;
    localparam logic [31:0] START = 32'b0000_1100_0000_1100_0110_0000_0110_0000;
    localparam logic [31:0] STOP  = 32'b0000_1100_0000_1100_0000_0110_0000_0110;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       chip_vld = 1'b0;
    logic [3:0] chip_slots = 4'b0000;
    logic       slot_skip, byte_vld, frame_err, frame_end, in_frame;
    logic [7:0] byte_data;

    always #2 clk = ~clk;

    ppm4_sync i_ppm4_sync (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .chip_vld   (chip_vld),
        .chip_slots (chip_slots),
        .slot_skip  (slot_skip),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .frame_err  (frame_err),
        .frame_end  (frame_end),
        .in_frame   (in_frame)
    );

    typedef struct {
        bit       skip;
        bit       bv;
        bit [7:0] data;
        bit       err;
        bit       fend;
        bit       inf;
        string    tag;
    } exp_t;

    exp_t expq[$];
    exp_t mon_e;
    int   checks = 0;
    int   fails  = 0;
    bit   took   = 1'b0;
    bit   done   = 1'b0;

    function automatic exp_t mk(bit skip, bit bv, bit [7:0] data, bit err, bit fend, bit inf, string tag);
        exp_t e;
        e.skip = skip; e.bv = bv; e.data = data; e.err = err; e.fend = fend; e.inf = inf; e.tag = tag;
        return e;
    endfunction

    function automatic logic [3:0] pre_chip(int k);
        return PRE[4*(3-k) +: 4];
    endfunction

    function automatic logic [3:0] flag_chip(logic [31:0] p, int k);
        return p[4*(7-k) +: 4];
    endfunction

    always @(posedge clk) took <= chip_vld && enable && !rst;

    always @(negedge clk) begin
        if (took) begin
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: chip taken with no expectation queued (actual skip=%0b bv=%0b err=%0b end=%0b, expected none)",
                         slot_skip, byte_vld, frame_err, frame_end);
            end else begin
                mon_e = expq.pop_front();
                checks++;
                if (slot_skip !== mon_e.skip || byte_vld !== mon_e.bv || frame_err !== mon_e.err ||
                    frame_end !== mon_e.fend || in_frame !== mon_e.inf ||
                    (mon_e.bv && byte_data !== mon_e.data)) begin
                    fails++;
                    $display("FAIL %s: actual skip=%0b bv=%0b data=%02h err=%0b end=%0b inf=%0b, expected skip=%0b bv=%0b data=%02h err=%0b end=%0b inf=%0b",
                             mon_e.tag, slot_skip, byte_vld, byte_data, frame_err, frame_end, in_frame,
                             mon_e.skip, mon_e.bv, mon_e.data, mon_e.err, mon_e.fend, mon_e.inf);
                end
            end
        end else if (!rst && (slot_skip || byte_vld || frame_err || frame_end)) begin
            fails++;
            $display("FAIL R1: pulse without a chip (actual skip=%0b bv=%0b err=%0b end=%0b, expected all 0)",
                     slot_skip, byte_vld, frame_err, frame_end);
        end
    end

    task automatic check(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h, expected %0h", req, actual, expected);
        end
    endtask

    task automatic send_chip(logic [3:0] c, exp_t e);
        expq.push_back(e);
        @(negedge clk);
        chip_vld   = 1'b1;
        chip_slots = c;
        @(negedge clk);
        chip_vld   = 1'b0;
    endtask

    task automatic send_pre(int groups);
        for (int g = 0; g < groups; g++)
            for (int k = 0; k < 4; k++)
                send_chip(pre_chip(k), mk(0, 0, 8'h00, 0, 0, 0, "R3 preamble repeat"));
    endtask

    task automatic send_start(int bad_at);
        for (int k = 0; k < 8; k++) begin
            if (k == bad_at) begin
                send_chip(4'b1111, mk(0, 0, 8'h00, 1, 0, 0, "R5 start flag mismatch"));
                return;
            end
            send_chip(flag_chip(START, k), mk(0, 0, 8'h00, 0, 0, k == 7, "R4 start flag"));
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int k = 0; k < 4; k++)
            send_chip(4'b1000 >> b[2*k +: 2], mk(0, k == 3, b, 0, 0, 1, "R6 data byte"));
    endtask

    task automatic send_stop(int bad_at, logic [3:0] bad_chip);
        for (int k = 0; k < 8; k++) begin
            if (k == bad_at) begin
                send_chip(bad_chip, mk(0, 0, 8'h00, 1, 0, 0, "R9 stop flag mismatch"));
                return;
            end
            send_chip(flag_chip(STOP, k), mk(0, 0, 8'h00, 0, k == 7, k != 7, "R8 stop flag"));
        end
    endtask

    function automatic logic slot_at(int i);
        return PRE[15 - (i % 16)];
    endfunction

    task automatic hunt_from(int offset);
        int  pos = offset;
        int  skips = 0;
        bit  matched = 1'b0;
        for (int g = 0; g < 20 && !matched; g++) begin
            int start = pos;
            matched = ((start % 16) == 0);
            for (int k = 0; k < 4; k++) begin
                logic [3:0] c = {slot_at(pos), slot_at(pos+1), slot_at(pos+2), slot_at(pos+3)};
                pos += 4;
                send_chip(c, mk(k == 3 && !matched, 0, 8'h00, 0, 0, 0, "R2 hunt skip"));
            end
            if (!matched) begin
                pos += 1;
                skips++;
            end
        end
        check(skips == 11, "R2 skip count from offset 5", skips, 11);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!slot_skip && !byte_vld && !frame_err && !frame_end && !in_frame && byte_data == 8'h00,
              "R1 reset outputs", {slot_skip, byte_vld, frame_err, frame_end, in_frame}, 0);
        rst = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);

        // R2, R3: hunt from a misaligned boundary, then long idle preamble
        hunt_from(5);
        send_pre(20);

        // R4, R6, R8: full frame
        send_pre(16);
        send_start(-1);
        send_byte(8'hA5);
        send_byte(8'h3C);
        send_byte(8'h00);
        send_byte(8'hFF);
        send_stop(-1, 4'b0000);
        check(!in_frame, "R8 in_frame low after stop", in_frame, 0);

        // R5: corrupt start flag chip 5
        send_pre(16);
        send_start(5);
        send_pre(2);

        // R7: non-one-hot chip in the middle of a byte
        send_pre(16);
        send_start(-1);
        send_byte(8'h5A);
        send_chip(4'b1000, mk(0, 0, 8'h00, 0, 0, 1, "R7 partial byte"));
        send_chip(4'b0100, mk(0, 0, 8'h00, 0, 0, 1, "R7 partial byte"));
        send_chip(4'b1111, mk(0, 0, 8'h00, 1, 0, 0, "R7 stray chip mid byte"));

        // R7: non-one-hot at group boundary that is not the stop flag
        send_pre(16);
        send_start(-1);
        send_chip(4'b0110, mk(0, 0, 8'h00, 1, 0, 0, "R7 stray chip at boundary"));

        // R9: stop flag wrong at chip 4
        send_pre(16);
        send_start(-1);
        send_byte(8'hC3);
        send_stop(4, 4'b1000);

        // R10: loss of lock, then clean reacquire and frame
        send_pre(2);
        send_chip(pre_chip(0), mk(0, 0, 8'h00, 0, 0, 0, "R10 before loss"));
        send_chip(pre_chip(1), mk(0, 0, 8'h00, 0, 0, 0, "R10 before loss"));
        send_chip(4'b0010,     mk(0, 0, 8'h00, 0, 0, 0, "R10 loss without skip or error"));
        send_pre(2);
        send_start(-1);
        send_byte(8'h96);
        send_stop(-1, 4'b0000);

        // R1: disable mid frame
        send_pre(16);
        send_start(-1);
        send_chip(4'b0001, mk(0, 0, 8'h00, 0, 0, 1, "R1 partial before disable"));
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!in_frame, "R1 in_frame cleared by disable", in_frame, 0);
        chip_vld   = 1'b1;
        chip_slots = 4'b0100;
        @(negedge clk);
        chip_vld   = 1'b0;
        check(!in_frame && !byte_vld && !frame_err, "R1 chip ignored while disabled",
              {in_frame, byte_vld, frame_err}, 0);
        enable = 1'b1;
        @(negedge clk);
        send_pre(2);
        send_start(-1);
        send_byte(8'h17);
        send_stop(-1, 4'b0000);

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule